// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reload Arming

This block is a supervisory timer that forces a chip reset when software stops servicing it. Its timebase divides the system clock first by a fixed divider (6 by default) and then by a binary prescaler (11 bits by default, i.e. 2048). Each prescaler wrap advances an 8-bit up-counter. When that counter rolls over from its all-ones value, the block issues a one-cycle reset pulse.

The watchdog is stopped after reset. It starts the first time software loads a value into the counter. A load is honoured only if software has first set a separate arming flag through its own strobe. The flag drops by itself when the load is taken, so every refresh needs an explicit arm-then-load pair. A key register holding the unlock value 55h holds the whole timebase still and marks power-down as permitted. Any other key value lets the count run and forbids power-down. A load of value v gives a reset after (256 − v) timer periods.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, wdt_reset and load_armed are 0, the key register holds 00h (pd_allowed 0), and the watchdog is stopped, so no reset pulse occurs however long it waits without a load.
- R2: A cycle with arm_set high makes load_armed 1 from the next cycle on. It stays 1 until a load is accepted or an expiry occurs.
- R3: load_wr while load_armed is 1 is accepted. From the next cycle the counter holds load_data, load_armed is 0 and the watchdog runs.
- R4: load_wr while load_armed is 0 is ignored. A stopped watchdog stays stopped, and a running one keeps its original expiry time.
- R5: An accepted load of value v clears the prescaler and divider. wdt_reset then rises exactly (256 − v) × DIV × 2^PRESC_W clock cycles after the load edge. v = 0 gives 256 periods.
- R6: An accepted load before expiry restarts the whole interval from the new load edge.
- R7: key_wr stores key_data, which takes effect from the next cycle. While the key is 55h, pd_allowed is 1 and the timebase and counter hold their state. Any other key sets pd_allowed to 0, and counting resumes from the frozen point.
- R8: wdt_reset is high for one cycle only. After it the watchdog is stopped and load_armed is 0 until armed again.
- R9: When an accepted load and an expiry fall in the same cycle, the load wins and no reset pulse is issued. When arm_set coincides with an accepted load, load_armed ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| key_wr | input | 1 | Write strobe for the key register |
| key_data | input | 8 | Key value; 55h disables counting and permits power-down |
| load_wr | input | 1 | Counter load strobe |
| load_data | input | 8 | Value loaded into the 8-bit counter |
| arm_set | input | 1 | Sets the load arming flag |
| wdt_reset | output | 1 | One-cycle reset request on counter rollover |
| pd_allowed | output | 1 | High while the key register holds 55h |
| load_armed | output | 1 | Current state of the load arming flag |

## Verification
The hardest case to reach is an accepted refresh that lands in the very cycle the counter would roll over. That exact cycle is known only by counting the full divided interval from the previous load. The bench therefore shrinks the prescaler with a parameter, loads FFh so that a single timer period remains, and arms during the wait. It then asserts the next load on the computed expiry cycle. Freezing and resuming through the key is reached the same way: the key is written mid-interval, and the remaining cycle count is tracked by a behavioural countdown model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int KEY_W = 8;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 8'h55;

    // control view shared from the controller to the datapath
    typedef struct packed {
        logic load_acc;   // armed load taken this cycle
        logic active;     // running and not unlocked by key
    } wdt_ctl_t;

    function automatic logic key_unlocks(input logic [KEY_W-1:0] k);
        return k == UNLOCK_KEY;
    endfunction

endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
    parameter int DIV     = 6,
    parameter int PRESC_W = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] DLAST = DW'(DIV - 1);

    logic [DW-1:0]      div_q;
    logic [PRESC_W-1:0] pre_q;
    logic               div_wrap;

    assign div_wrap = en && (div_q == DLAST);
    assign tick     = div_wrap && (pre_q == '1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
            pre_q <= '0;
        end else if (en) begin
            div_q <= div_wrap ? '0 : div_q + 1'b1;
            if (div_wrap)
                pre_q <= pre_q + 1'b1;
        end
    end

    // R7
    frozen_base_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> ($stable(pre_q) && $stable(div_q)));

    // R5
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (div_q == '0 && pre_q == '0));

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          ovf
);
    logic [TW-1:0] cnt_q;

    assign ovf = tick && (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

    // R7
    hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_data,
    input  logic             load_wr,
    input  logic             arm_set,
    input  logic             ovf,
    output wdt_ctl_t         ctl,
    output logic             pd_ok,
    output logic             armed_o,
    output logic             pulse_o
);
    logic [KEY_W-1:0] key_q;
    logic             armed_q;
    logic             run_q;
    logic             pulse_q;
    logic             expire;

    always_comb begin
        ctl.load_acc = load_wr && armed_q;
        ctl.active   = run_q && !key_unlocks(key_q);
        expire       = ovf && !ctl.load_acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q   <= '0;
            armed_q <= 1'b0;
            run_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (key_wr)
                key_q <= key_data;
            pulse_q <= expire;
            if (ctl.load_acc)
                run_q <= 1'b1;
            else if (expire)
                run_q <= 1'b0;
            if (ctl.load_acc || expire)
                armed_q <= 1'b0;
            else if (arm_set)
                armed_q <= 1'b1;
        end
    end

    assign pd_ok   = key_unlocks(key_q);
    assign armed_o = armed_q;
    assign pulse_o = pulse_q;

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    // R8
    pulse_stop_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> (!run_q && !armed_q));

    // R3
    load_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.load_acc |=> (!armed_q && run_q));

    // R4
    unarmed_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (load_wr && !armed_q && !run_q) |=> !run_q);

    // R2
    arm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (arm_set && !ctl.load_acc && !expire) |=> armed_q);

    // R7
    locked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        pd_ok |-> !ovf);

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int DIV     = 6,
    parameter int PRESC_W = 11,
    parameter int TW      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_data,
    input  logic             load_wr,
    input  logic [TW-1:0]    load_data,
    input  logic             arm_set,
    output logic             wdt_reset,
    output logic             pd_allowed,
    output logic             load_armed
);
    wdt_ctl_t ctl;
    logic     tmr_tick;
    logic     ovf;

    wdt_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (key_wr),
        .key_data (key_data),
        .load_wr  (load_wr),
        .arm_set  (arm_set),
        .ovf      (ovf),
        .ctl      (ctl),
        .pd_ok    (pd_allowed),
        .armed_o  (load_armed),
        .pulse_o  (wdt_reset)
    );

    wdt_timebase #(.DIV(DIV), .PRESC_W(PRESC_W)) u_base (
        .clk  (clk),
        .rst  (rst),
        .en   (ctl.active),
        .clr  (ctl.load_acc),
        .tick (tmr_tick)
    );

    wdt_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .tick     (tmr_tick),
        .load     (ctl.load_acc),
        .load_val (load_data),
        .ovf      (ovf)
    );

    // R9
    load_beats_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && ctl.load_acc) |=> !wdt_reset);

endmodule

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;
    localparam int DIV = 6;
    localparam int PW  = 2;
    localparam int TPT = DIV * (1 << PW);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_wr = 1'b0;
    logic [7:0] key_data = 8'h00;
    logic       load_wr = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic       arm_set = 1'b0;
    logic       wdt_reset, pd_allowed, load_armed;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    int       m_remain = 0;
    bit       m_run = 0, m_arm = 0, m_pulse = 0, m_exp = 0, m_acc = 0;
    bit [7:0] m_key = 8'h00;

    always #2 clk = ~clk;

    wdt_keyed #(.DIV(DIV), .PRESC_W(PW), .TW(8)) uut (
        .clk(clk), .rst(rst), .key_wr(key_wr), .key_data(key_data),
        .load_wr(load_wr), .load_data(load_data), .arm_set(arm_set),
        .wdt_reset(wdt_reset), .pd_allowed(pd_allowed), .load_armed(load_armed)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_remain = 0; m_run = 0; m_arm = 0; m_pulse = 0; m_key = 8'h00;
        end else begin
            m_pulse = 0;
            m_exp   = 0;
            m_acc   = load_wr && m_arm;
            if (m_acc) begin
                m_remain = (256 - int'(load_data)) * TPT;
                m_run = 1;
            end else if (m_run && m_key != 8'h55) begin
                m_remain = m_remain - 1;
                if (m_remain == 0) begin
                    m_exp = 1; m_pulse = 1; m_run = 0;
                end
            end
            if (m_acc || m_exp) m_arm = 0;
            else if (arm_set)   m_arm = 1;
            if (key_wr) m_key = key_data;
        end
    end

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(wdt_reset == m_pulse, "R5 wdt_reset", int'(wdt_reset), int'(m_pulse));
            chk(load_armed == m_arm, "R2 load_armed", int'(load_armed), int'(m_arm));
            chk(pd_allowed == (m_key == 8'h55), "R7 pd_allowed", int'(pd_allowed), int'(m_key == 8'h55));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired got %0d expected %0d", cyc, 200000);
            finish_run();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_arm();
        arm_set = 1'b1; @(negedge clk); arm_set = 1'b0;
    endtask

    task automatic do_load(input logic [7:0] v);
        load_wr = 1'b1; load_data = v; @(negedge clk); load_wr = 1'b0;
    endtask

    task automatic do_key(input logic [7:0] k);
        key_wr = 1'b1; key_data = k; @(negedge clk); key_wr = 1'b0;
    endtask

    // called just after do_load returned (negedge index 1)
    task automatic wait_pulse(input int limit, output int k);
        k = 1;
        while (!wdt_reset && k < limit) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        int k;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(wdt_reset == 1'b0, "R1 reset pulse", int'(wdt_reset), 0);
        chk(load_armed == 1'b0, "R1 reset armed", int'(load_armed), 0);
        chk(pd_allowed == 1'b0, "R1 reset key", int'(pd_allowed), 0);
        idle(300);
        chk(wdt_reset == 1'b0, "R1 stopped stays quiet", int'(wdt_reset), 0);

        // R4 unarmed load on a stopped watchdog
        do_load(8'hFE);
        idle(200);
        chk(load_armed == 1'b0, "R4 unarmed load ignored", int'(load_armed), 0);

        // R2 arm and hold
        do_arm();
        idle(5);
        chk(load_armed == 1'b1, "R2 armed holds", int'(load_armed), 1);

        // R3, R5 armed load of FEh -> 2 periods
        do_load(8'hFE);
        chk(load_armed == 1'b0, "R3 load disarms", int'(load_armed), 0);
        wait_pulse(10000, k);
        chk(k == 2 * TPT + 1, "R5 interval FEh", k, 2 * TPT + 1);
        @(negedge clk);
        chk(wdt_reset == 1'b0, "R8 pulse one cycle", int'(wdt_reset), 0);
        chk(load_armed == 1'b0, "R8 armed clear after pulse", int'(load_armed), 0);
        idle(400);
        chk(wdt_reset == 1'b0, "R8 stopped after pulse", int'(wdt_reset), 0);

        // R6 refresh restarts; R4 unarmed load mid-run ignored
        do_arm();
        do_load(8'hF0);
        idle(100);
        do_load(8'h00);
        idle(100);
        do_arm();
        do_load(8'hF0);
        wait_pulse(10000, k);
        chk(k == 16 * TPT + 1, "R6 restart interval", k, 16 * TPT + 1);

        // R7 key freeze and resume
        do_key(8'h55);
        chk(pd_allowed == 1'b1, "R7 key unlock", int'(pd_allowed), 1);
        do_arm();
        do_load(8'hF8);
        idle(100);
        do_key(8'h55);
        idle(2000);
        chk(wdt_reset == 1'b0, "R7 frozen no pulse", int'(wdt_reset), 0);
        do_key(8'hAA);
        chk(pd_allowed == 1'b0, "R7 key relock", int'(pd_allowed), 0);
        wait_pulse(10000, k);
        chk(wdt_reset == 1'b1, "R7 resumed to expiry", int'(wdt_reset), 1);
        @(negedge clk);

        // R9 arm together with accepted load
        do_arm();
        arm_set = 1'b1; load_wr = 1'b1; load_data = 8'hFF;
        @(negedge clk);
        arm_set = 1'b0; load_wr = 1'b0;
        chk(load_armed == 1'b0, "R9 arm with load ends clear", int'(load_armed), 0);
        // R9 load on the expiry cycle: now at negedge index 1 of a FFh load
        do_arm();
        idle(TPT - 2);
        do_load(8'hF0);
        chk(wdt_reset == 1'b0, "R9 load beats expiry", int'(wdt_reset), 0);
        wait_pulse(10000, k);
        chk(k == 16 * TPT + 1, "R9 interval after rescue", k, 16 * TPT + 1);

        // R5 boundary v = 0
        do_arm();
        do_load(8'h00);
        wait_pulse(20000, k);
        chk(k == 256 * TPT + 1, "R5 interval 00h", k, 256 * TPT + 1);
        idle(5);
        finish_run();
    end
endmodule